// File: doc/BRIEF.md
# Mailbox Channel Request Router

The router sits between a host register port and a set of channel endpoints. A host write that lands in the send window carries a 32-bit message. Its low four bits name the destination channel. If that channel is idle, the message goes to the channel's request port one cycle later. If the channel reports busy, the message is parked in an outbound queue instead. A message that names a channel which does not exist is dropped, and so is any send that arrives while the queue is full. Each drop raises a one-cycle error pulse. Parked messages stay in the queue. The host sees them only through a status word (full flag, empty flag and fill level) and a peek of the oldest parked word.

In the other direction, the router gathers responses from the channels into the host mailbox through a valid/ready push port. `hm_valid` is high whenever at least one channel reports a response. The word offered comes from the lowest-numbered channel that has one. A transfer completes in a cycle where `hm_ready` is also high, and only then is the pop strobe given to that channel. While the host side stalls, the offered channel is held and the choice does not move to a newer, lower-numbered arrival. This keeps the offered word stable. Because `hm_ready` low stands for a full host mailbox, collection pauses until space returns. At most one response moves per clock.

Top module: `mbox_router`

## Requirements
- R1: Only a write with `wr_en` high and `wr_addr` in the byte range 0xA0 to 0xAF is a send request. Writes at any other offset change no output and no queue state.
- R2: A send to a valid channel (low nibble of `wr_data` below NUM_CH) that is not busy produces, on the next cycle, a one-cycle pulse on `ch_req_valid` at bit [channel] only. `ch_req_data` carries the full word in that cycle.
- R3: A send to a valid channel whose `ch_pend` bit is high appends the whole word to the outbound queue. The fill level rises by one, and no request pulse and no error pulse follow.
- R4: A send that arrives while the queue holds Q_DEPTH words is dropped, whatever its channel number. `err_ovf` pulses for exactly the next cycle, and the level stays unchanged.
- R5: A send whose low nibble is NUM_CH or greater, with the queue not full, is dropped. `err_inv` pulses for exactly the next cycle, with no request pulse and no queue change.
- R6: `st_rdata` is combinational from `st_addr`. Offset 0xB8 returns bit 31 = queue full, bit 30 = queue empty and bits 7:0 = fill level, with all other bits 0. Offset 0xB0 returns the oldest queued word, or 0 when the queue is empty. Every other offset returns 0.
- R7: `hm_valid` is high exactly when some `ch_avail` bit is high. When no stall is in progress, `hm_data` is the response of the lowest-numbered available channel.
- R8: `ch_rsp_pop` has at most one bit set. It is set only for the channel being offered, and only in a cycle where both `hm_valid` and `hm_ready` are high.
- R9: After a cycle with `hm_valid` high and `hm_ready` low, the same channel stays selected for as long as it still reports available, even if a lower-numbered channel becomes available.
- R10: A response word equal to INVALID_WORD is never transferred to the host mailbox. Endpoints must not present it while their available bit is high.
- R11: After reset the queue is empty (status 0x4000_0000), and no request, error or pop strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write byte offset |
| wr_data | input | 32 | Host write data; bits 3:0 select the channel |
| st_addr | input | 8 | Status read offset |
| st_rdata | output | 32 | Status read data |
| ch_pend | input | NUM_CH | Per-channel busy flag |
| ch_req_valid | output | NUM_CH | One-cycle request strobe per channel |
| ch_req_data | output | 32 | Request word for the strobed channel |
| ch_avail | input | NUM_CH | Per-channel response available |
| ch_rsp_data | input | NUM_CH*32 | Response words, channel i at bits [32*i +: 32] |
| ch_rsp_pop | output | NUM_CH | Response consumed strobe per channel |
| hm_valid | output | 1 | Response offered to host mailbox |
| hm_ready | input | 1 | Host mailbox has space |
| hm_data | output | 32 | Response word offered |
| err_ovf | output | 1 | Pulse: send dropped, queue full |
| err_inv | output | 1 | Pulse: send dropped, invalid channel |

## Verification
The bench uses the default build: nine channels and a four-entry queue. With nine channels, channel numbers 9 to 15 reach the invalid-channel path while 0 to 8 stay valid. The last channel, 8, sits at the top of the scan order, and the collection priority and stall hold can be seen across more than eight competing sources. The shallow queue fills after four busy sends, so the overflow path and its precedence over the invalid-channel check come up many times in each random episode between resets.

// File: rtl/mbox_router_pkg.sv
package mbox_router_pkg;

  localparam int          SEL_W       = 4;
  localparam logic [7:0]  SEND_LO     = 8'hA0;
  localparam logic [7:0]  SEND_HI     = 8'hAF;
  localparam logic [7:0]  STAT_OFS    = 8'hB8;
  localparam logic [7:0]  PEEK_OFS    = 8'hB0;
  localparam int          FULL_BIT    = 31;
  localparam int          EMPTY_BIT   = 30;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FWD,
    ACT_QUEUE,
    ACT_OVF,
    ACT_INV
  } send_act_e;

endpackage

// File: rtl/mbox_send_decode.sv
module mbox_send_decode
  import mbox_router_pkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_CH-1:0] ch_pend,
  input  logic              q_full,
  output logic              q_push,
  output logic [DATA_W-1:0] q_data,
  output logic [NUM_CH-1:0] req_valid,
  output logic [DATA_W-1:0] req_data,
  output logic              err_ovf,
  output logic              err_inv
);

  logic [SEL_W-1:0]  ch_sel;
  logic              in_window;
  logic              ch_ok;
  logic              pend_hit;
  send_act_e         act;
  logic [NUM_CH-1:0] req_valid_d;
  logic [NUM_CH-1:0] req_valid_q;
  logic [DATA_W-1:0] req_data_q;
  logic              err_ovf_q;
  logic              err_inv_q;

  assign ch_sel    = wr_data[SEL_W-1:0];
  assign in_window = wr_en && (wr_addr >= SEND_LO) && (wr_addr <= SEND_HI);
  assign ch_ok     = (int'(ch_sel) < NUM_CH);

  always_comb begin
    pend_hit = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == SEL_W'(i)) pend_hit = ch_pend[i];
    end
  end

  // queue capacity is checked before the channel number
  always_comb begin
    act = ACT_NONE;
    if (in_window) begin
      if (q_full)        act = ACT_OVF;
      else if (!ch_ok)   act = ACT_INV;
      else if (pend_hit) act = ACT_QUEUE;
      else               act = ACT_FWD;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      req_valid_d[i] = (act == ACT_FWD) && (ch_sel == SEL_W'(i));
    end
  end

  assign q_push = (act == ACT_QUEUE);
  assign q_data = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid_q <= '0;
      req_data_q  <= '0;
      err_ovf_q   <= 1'b0;
      err_inv_q   <= 1'b0;
    end else begin
      req_valid_q <= req_valid_d;
      err_ovf_q   <= (act == ACT_OVF);
      err_inv_q   <= (act == ACT_INV);
      if (act == ACT_FWD) req_data_q <= wr_data;
    end
  end

  assign req_valid = req_valid_q;
  assign req_data  = req_data_q;
  assign err_ovf   = err_ovf_q;
  assign err_inv   = err_inv_q;

  // R2
  fwd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid));

  // R4
  ovf_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && q_full) |=> (err_ovf && !err_inv && req_valid == '0));

  // R5
  inv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_inv |-> (!err_ovf && req_valid == '0));

  // R1
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |=> (!err_ovf && !err_inv && req_valid == '0));

endmodule

// File: rtl/mbox_out_fifo.sv
module mbox_out_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic [DATA_W-1:0] head
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LVL_W-1:0]  level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (push && !full) begin
      level_q <= level_q + LVL_W'(1);
    end
  end

  // storage carries no reset; head is masked while empty
  always_ff @(posedge clk) begin
    if (rst_n && push && !full) begin
      mem[level_q[IDX_W-1:0]] <= push_data;
    end
  end

  assign level = level_q;
  assign full  = (level_q == LVL_W'(DEPTH));
  assign empty = (level_q == '0);
  assign head  = empty ? '0 : mem[0];

  // R3
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (level == $past(level) + LVL_W'(1)));

  // R4
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

endmodule

// File: rtl/mbox_rsp_collect.sv
module mbox_rsp_collect #(
  parameter int          NUM_CH       = 9,
  parameter int          DATA_W       = 32,
  parameter logic [31:0] INVALID_WORD = 32'h0000_000F,
  localparam int         IW           = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        avail,
  input  logic [NUM_CH*DATA_W-1:0] rsp_data,
  output logic [NUM_CH-1:0]        pop,
  output logic                     hm_valid,
  input  logic                     hm_ready,
  output logic [DATA_W-1:0]        hm_data
);

  logic [IW-1:0] low_idx;
  logic [IW-1:0] sel_idx;
  logic          lock_q;
  logic [IW-1:0] lock_idx_q;
  logic          lock_live;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (avail[i]) low_idx = IW'(i);
    end
  end

  always_comb begin
    lock_live = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (lock_idx_q == IW'(i)) lock_live = lock_q && avail[i];
    end
  end

  assign sel_idx  = lock_live ? lock_idx_q : low_idx;
  assign hm_valid = |avail;

  always_comb begin
    hm_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_idx == IW'(i)) hm_data = rsp_data[i*DATA_W +: DATA_W];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_pop
      assign pop[g] = hm_valid && hm_ready && (sel_idx == IW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= hm_valid && !hm_ready;
      lock_idx_q <= sel_idx;
    end
  end

  // R8
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop) && (hm_ready || pop == '0) && ((pop & ~avail) == '0));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hm_valid && !hm_ready) |=>
      (!avail[$past(sel_idx)] || sel_idx == $past(sel_idx)));

  // R10
  no_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hm_valid && hm_ready) |-> (hm_data != DATA_W'(INVALID_WORD)));

  // R7
  valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hm_valid |-> avail[sel_idx]);

endmodule

// File: rtl/mbox_router.sv
module mbox_router
  import mbox_router_pkg::*;
#(
  parameter int          NUM_CH       = 9,
  parameter int          DATA_W       = 32,
  parameter int          Q_DEPTH      = 4,
  parameter logic [31:0] INVALID_WORD = 32'h0000_000F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [7:0]               wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [7:0]               st_addr,
  output logic [DATA_W-1:0]        st_rdata,
  input  logic [NUM_CH-1:0]        ch_pend,
  output logic [NUM_CH-1:0]        ch_req_valid,
  output logic [DATA_W-1:0]        ch_req_data,
  input  logic [NUM_CH-1:0]        ch_avail,
  input  logic [NUM_CH*DATA_W-1:0] ch_rsp_data,
  output logic [NUM_CH-1:0]        ch_rsp_pop,
  output logic                     hm_valid,
  input  logic                     hm_ready,
  output logic [DATA_W-1:0]        hm_data,
  output logic                     err_ovf,
  output logic                     err_inv
);

  localparam int LVL_W = $clog2(Q_DEPTH + 1);

  logic              q_push;
  logic [DATA_W-1:0] q_data;
  logic [LVL_W-1:0]  q_level;
  logic              q_full;
  logic              q_empty;
  logic [DATA_W-1:0] q_head;

  mbox_send_decode #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ch_pend   (ch_pend),
    .q_full    (q_full),
    .q_push    (q_push),
    .q_data    (q_data),
    .req_valid (ch_req_valid),
    .req_data  (ch_req_data),
    .err_ovf   (err_ovf),
    .err_inv   (err_inv)
  );

  mbox_out_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (Q_DEPTH)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (q_data),
    .level     (q_level),
    .full      (q_full),
    .empty     (q_empty),
    .head      (q_head)
  );

  mbox_rsp_collect #(
    .NUM_CH       (NUM_CH),
    .DATA_W       (DATA_W),
    .INVALID_WORD (INVALID_WORD)
  ) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .avail    (ch_avail),
    .rsp_data (ch_rsp_data),
    .pop      (ch_rsp_pop),
    .hm_valid (hm_valid),
    .hm_ready (hm_ready),
    .hm_data  (hm_data)
  );

  always_comb begin
    st_rdata = '0;
    if (st_addr == STAT_OFS) begin
      st_rdata[FULL_BIT]    = q_full;
      st_rdata[EMPTY_BIT]   = q_empty;
      st_rdata[LVL_W-1:0]   = q_level;
    end else if (st_addr == PEEK_OFS) begin
      st_rdata = q_head;
    end
  end

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (ch_req_valid == '0 && !err_ovf && !err_inv && q_empty));

endmodule

// File: tb/mbox_router_tb.sv
module mbox_router_tb;

  localparam int          N   = 9;
  localparam int          DW  = 32;
  localparam int          QD  = 4;
  localparam logic [31:0] INV = 32'h0000_000F;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [7:0]      st_addr = 8'hB8;
  logic [DW-1:0]   st_rdata;
  logic [N-1:0]    ch_pend = '0;
  logic [N-1:0]    ch_req_valid;
  logic [DW-1:0]   ch_req_data;
  logic [N-1:0]    ch_avail = '0;
  logic [N*DW-1:0] ch_rsp_data = '0;
  logic [N-1:0]    ch_rsp_pop;
  logic            hm_valid;
  logic            hm_ready = 1'b0;
  logic [DW-1:0]   hm_data;
  logic            err_ovf;
  logic            err_inv;

  int tests = 0;
  int fails = 0;

  // bench model state
  int            m_level;
  logic [DW-1:0] m_q [QD];
  logic [N-1:0]  e_req;
  logic [DW-1:0] e_req_data;
  logic          e_ovf, e_inv;
  logic          m_lock;
  int            m_lock_idx;

  always #10 clk = ~clk;

  mbox_router #(.NUM_CH(N), .DATA_W(DW), .Q_DEPTH(QD), .INVALID_WORD(INV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .st_addr(st_addr), .st_rdata(st_rdata), .ch_pend(ch_pend),
    .ch_req_valid(ch_req_valid), .ch_req_data(ch_req_data), .ch_avail(ch_avail),
    .ch_rsp_data(ch_rsp_data), .ch_rsp_pop(ch_rsp_pop), .hm_valid(hm_valid),
    .hm_ready(hm_ready), .hm_data(hm_data), .err_ovf(err_ovf), .err_inv(err_inv)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input logic [7:0] a);
    logic [31:0] v = '0;
    if (a == 8'hB8) begin
      v[31]  = (m_level == QD);
      v[30]  = (m_level == 0);
      v[7:0] = 8'(m_level);
    end else if (a == 8'hB0) begin
      v = (m_level > 0) ? m_q[0] : '0;
    end
    return v;
  endfunction

  function automatic int lowest(input logic [N-1:0] a);
    for (int i = 0; i < N; i++) if (a[i]) return i;
    return 0;
  endfunction

  function automatic logic [DW-1:0] rsp_word();
    logic [DW-1:0] w = $urandom;
    if (w == INV) w = w ^ 32'h1;
    return w;
  endfunction

  task automatic clear_model();
    m_level = 0; e_req = '0; e_req_data = '0; e_ovf = 1'b0; e_inv = 1'b0;
    m_lock = 1'b0; m_lock_idx = 0;
    for (int i = 0; i < QD; i++) m_q[i] = '0;
  endtask

  // one clock: drive at negedge, check combinational paths, then registered ones
  task automatic cycle(input logic we, input logic [7:0] a, input logic [DW-1:0] d,
                       input logic [N-1:0] pend, input logic [N-1:0] av,
                       input logic rdy, input logic [7:0] sa);
    int sel;
    logic vexp;
    logic [N-1:0] pexp;
    int ch;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; ch_pend = pend; ch_avail = av;
    hm_ready = rdy; st_addr = sa;
    for (int i = 0; i < N; i++) ch_rsp_data[i*DW +: DW] = rsp_word();
    #5;
    vexp = |av;
    sel  = (m_lock && av[m_lock_idx]) ? m_lock_idx : lowest(av);
    pexp = (vexp && rdy) ? N'(1) << sel : '0;
    check(hm_valid == vexp, "R7", "hm_valid", 32'(hm_valid), 32'(vexp));
    if (vexp)
      check(hm_data == ch_rsp_data[sel*DW +: DW], (m_lock ? "R9" : "R7"), "hm_data",
            hm_data, ch_rsp_data[sel*DW +: DW]);
    check(ch_rsp_pop == pexp, "R8", "ch_rsp_pop", 32'(ch_rsp_pop), 32'(pexp));
    check(st_rdata == exp_status(sa), "R6", "st_rdata", st_rdata, exp_status(sa));
    // send model
    e_req = '0; e_ovf = 1'b0; e_inv = 1'b0;
    ch = int'(d[3:0]);
    if (we && a >= 8'hA0 && a <= 8'hAF) begin
      if (m_level == QD) e_ovf = 1'b1;
      else if (ch >= N) e_inv = 1'b1;
      else if (pend[ch]) begin m_q[m_level] = d; m_level++; end
      else begin e_req = N'(1) << ch; e_req_data = d; end
    end
    m_lock = vexp && !rdy;
    m_lock_idx = sel;
    @(posedge clk); #1;
    check(ch_req_valid == e_req, "R2", "ch_req_valid", 32'(ch_req_valid), 32'(e_req));
    if (e_req != '0)
      check(ch_req_data == e_req_data, "R2", "ch_req_data", ch_req_data, e_req_data);
    check(err_ovf == e_ovf, "R4", "err_ovf", 32'(err_ovf), 32'(e_ovf));
    check(err_inv == e_inv, "R5", "err_inv", 32'(err_inv), 32'(e_inv));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; ch_avail = '0; hm_ready = 1'b0; st_addr = 8'hB8;
    repeat (2) @(posedge clk);
    #1;
    clear_model();
    check(st_rdata == 32'h4000_0000, "R11", "reset status", st_rdata, 32'h4000_0000);
    check(ch_req_valid == '0 && !err_ovf && !err_inv, "R11", "reset strobes",
          {ch_req_valid, err_ovf, err_inv}, '0);
    check(ch_rsp_pop == '0 && !hm_valid, "R11", "reset pop", 32'(ch_rsp_pop), '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] rand_addr();
    int r = $urandom_range(0, 9);
    if (r < 8) return 8'hA0 + 8'(4 * (r % 4));
    return 8'($urandom);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_model();
    do_reset();

    // R1: write outside window does nothing
    cycle(1, 8'h9C, 32'h1234_5602, '0, '0, 1, 8'hB8);
    cycle(1, 8'hB0, 32'h1234_5603, '0, '0, 1, 8'hB8);
    // R2: forward to first, last and mid channel (offsets 0xA0, 0xAC)
    cycle(1, 8'hA0, 32'hCAFE_0000, '0, '0, 1, 8'hB8);
    cycle(1, 8'hAC, 32'hBEEF_0008, '0, '0, 1, 8'hB8);
    cycle(1, 8'hA8, 32'h0101_0103, 9'h0F7, '0, 1, 8'hB8);
    // R5: invalid channels 9 and 15
    cycle(1, 8'hA4, 32'h0000_0009, '0, '0, 1, 8'hB8);
    cycle(1, 8'hA4, 32'h0000_001F, '0, '0, 1, 8'hB8);
    // R3: queue four busy sends, status and peek
    for (int k = 0; k < QD; k++)
      cycle(1, 8'hA0, 32'h5A00_0010 + 32'(k << 8) + 32'(k), '1, '0, 1, 8'hB0);
    cycle(0, 8'h00, '0, '0, '0, 1, 8'hB8);
    // R4: full queue drops idle, busy and invalid sends alike
    cycle(1, 8'hA0, 32'h0000_0002, '0, '0, 1, 8'hB8);
    cycle(1, 8'hA0, 32'h0000_000C, '0, '0, 1, 8'hB8);
    cycle(1, 8'hA0, 32'h0000_0004, '1, '0, 1, 8'hB0);
    // R7/R8: lowest of ch5, ch2
    cycle(0, 8'h00, '0, '0, 9'h024, 1, 8'hB8);
    cycle(0, 8'h00, '0, '0, 9'h100, 1, 8'hB8);
    // R9: stall on ch5, then ch1 appears, selection holds; R8: no pop while stalled
    cycle(0, 8'h00, '0, '0, 9'h020, 0, 8'hB8);
    cycle(0, 8'h00, '0, '0, 9'h022, 0, 8'hB8);
    cycle(0, 8'h00, '0, '0, 9'h022, 1, 8'hB8);
    cycle(0, 8'h00, '0, '0, 9'h002, 1, 8'hB8);

    // random episodes
    for (int ep = 0; ep < 6; ep++) begin
      do_reset();
      for (int n = 0; n < 300; n++) begin
        cycle(($urandom_range(0, 9) < 6), rand_addr(),
              {$urandom} & 32'hFFFF_FFF0 | 32'($urandom_range(0, 15)),
              N'($urandom), N'($urandom) & N'($urandom), ($urandom_range(0, 3) != 0),
              ($urandom_range(0, 3) == 0) ? 8'hB0 :
              (($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'hB8));
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule